// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block computes 32-bit products and quotients for an integer core, one bit per clock. A single-cycle start pulse carrying an operation code and two operands launches the work; the unit then iterates for a fixed number of cycles and raises a busy flag for the whole run. Full multiplies leave a 64-bit product split across two result registers: the upper word in HI and the lower word in LO. Divides reuse the same pair with a different meaning: the quotient lands in LO and the remainder in HI.

HI and LO are always visible on dedicated read ports, so move-from instructions copy them without any handshake. A third kind of multiply returns only the low word of the product on its own result port, together with a one-cycle valid pulse, and leaves HI and LO as they were. The hardware never flags a zero divisor or an overflowing quotient. Software is expected to guard against those cases and tolerate whatever values appear. The only interlock offered to the core is the busy flag.

Top module: `mdu_hilo`

## Requirements
- R1: While reset is applied, busy_o is 0, hi_o and lo_o read 0, mul_lo_o reads 0 and mul_lo_vld_o is 0.
- R2: Operation code 0 (signed multiply) writes the upper 32 bits of the two's-complement 64-bit product to hi_o and the lower 32 bits to lo_o.
- R3: Operation code 1 (unsigned multiply) writes the upper and lower halves of the unsigned 64-bit product to hi_o and lo_o; for example 5 times 3 gives hi_o = 0 and lo_o = 15.
- R4: Operation code 2 (signed divide) writes to lo_o the quotient rounded toward zero, and to hi_o a remainder that carries the sign of the dividend.
- R5: Operation code 3 (unsigned divide) writes the unsigned quotient to lo_o and the unsigned remainder to hi_o.
- R6: Operation code 4 (low-word multiply) puts the low 32 bits of the product on mul_lo_o and pulses mul_lo_vld_o for exactly one cycle, in the cycle busy_o falls; hi_o and lo_o keep their values.
- R7: An accepted start raises busy_o on the next cycle and keeps it high for exactly 32 cycles; the results appear in the first cycle with busy_o low.
- R8: A start while busy_o is high, including in the last busy cycle, is ignored and does not change the running operation or its timing; a start with operation codes 5, 6 or 7 is ignored and leaves busy_o low.
- R9: A divide with a zero divisor completes in the normal 32 busy cycles without any error indication, and the unit accepts the next operation normally.
- R10: hi_o and lo_o change only in the cycle in which busy_o falls after a full multiply or divide; they hold their values while idle and while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 3 | Operation code: 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 low-word multiply |
| opa_i | input | 32 | First operand: multiplier or dividend |
| opb_i | input | 32 | Second operand: multiplicand or divisor |
| busy_o | output | 1 | High while an operation is iterating |
| hi_o | output | 32 | HI register: upper product word or remainder |
| lo_o | output | 32 | LO register: lower product word or quotient |
| mul_lo_o | output | 32 | Low product word of the most recent low-word multiply |
| mul_lo_vld_o | output | 1 | One-cycle pulse when mul_lo_o is updated |

## Verification
The collision that matters is a new start request arriving in the same cycle in which a running operation finishes and writes HI and LO. The bench provokes this by raising start on the last busy cycle, and on randomly chosen earlier busy cycles, with a different operation and different operands. Such a request is judged correct when the busy run still lasts exactly 32 cycles, busy stays low afterwards, and HI/LO (or the low-word result) match the first operation, not the intruder.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MULS  = 3'd0,
    OP_MULU  = 3'd1,
    OP_DIVS  = 3'd2,
    OP_DIVU  = 3'd3,
    OP_MULLO = 3'd4
  } mdu_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mdu_state_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_div(input logic [2:0] code);
    return (code == OP_DIVS) || (code == OP_DIVU);
  endfunction

  function automatic logic op_is_signed(input logic [2:0] code);
    return (code == OP_MULS) || (code == OP_DIVS) || (code == OP_MULLO);
  endfunction

endpackage

// File: rtl/mdu_rst_sync.sv
module mdu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mdu_magnitude.sv
module mdu_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         sgn_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);

  always_comb begin
    neg_o = sgn_i & val_i[W-1];
    mag_o = neg_o ? (~val_i + 1'b1) : val_i;
  end

endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic           div_i,
  output logic [2*W-1:0] acc_o
);

  logic [W:0]   sum;
  logic [W:0]   trial;
  logic         fits;
  logic [W-1:0] rem_n;

  always_comb begin
    // shift-add: conditionally add the multiplicand, then shift right
    sum   = {1'b0, acc_i[2*W-1:W]} + {1'b0, (acc_i[0] ? opnd_i : {W{1'b0}})};
    // restoring divide: shift left by one and try the subtraction
    trial = acc_i[2*W-1:W-1];
    fits  = ({1'b0, opnd_i} <= trial);
    rem_n = trial[W-1:0] - opnd_i;
    if (!div_i) begin
      acc_o = {sum, acc_i[W-1:1]};
    end else if (fits) begin
      acc_o = {rem_n, acc_i[W-2:0], 1'b1};
    end else begin
      acc_o = {acc_i[2*W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/mdu_sign_fix.sv
module mdu_sign_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] raw_i,
  input  logic           div_i,
  input  logic           neg_a_i,
  input  logic           neg_b_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o
);

  logic [2*W-1:0] prod;
  logic [W-1:0]   quo;
  logic [W-1:0]   rem;

  always_comb begin
    prod = (neg_a_i ^ neg_b_i) ? (~raw_i + 1'b1) : raw_i;
    quo  = (neg_a_i ^ neg_b_i) ? (~raw_i[W-1:0] + 1'b1) : raw_i[W-1:0];
    rem  = neg_a_i ? (~raw_i[2*W-1:W] + 1'b1) : raw_i[2*W-1:W];
    if (div_i) begin
      hi_o = rem;
      lo_o = quo;
    end else begin
      hi_o = prod[2*W-1:W];
      lo_o = prod[W-1:0];
    end
  end

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] mul_lo_o,
  output logic         mul_lo_vld_o
);

  import mdu_pkg::*;

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic rst_sync_n;

  mdu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // state
  mdu_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [2*W-1:0] acc_q, acc_d;
  logic [W-1:0]   opnd_q;
  logic [2:0]     op_q;
  logic           nega_q, negb_q;
  logic [W-1:0]   hi_q, lo_q, mlo_q;
  logic           mvld_q, mvld_d;

  // operand conditioning
  logic [1:0][W-1:0] opnd_in;
  logic [1:0][W-1:0] mag;
  logic [1:0]        neg;
  logic              sgn_req;

  assign opnd_in[0] = opa_i;
  assign opnd_in[1] = opb_i;
  assign sgn_req    = op_is_signed(op_i);

  for (genvar g = 0; g < 2; g++) begin : g_mag
    mdu_magnitude #(.W(W)) u_mag (
      .val_i (opnd_in[g]),
      .sgn_i (sgn_req),
      .mag_o (mag[g]),
      .neg_o (neg[g])
    );
  end

  // control
  logic accept, running, finish;
  logic load_en, step_en, hilo_en, mlo_en;

  assign running = (state_q == ST_RUN);
  assign accept  = start_i && !running && op_known(op_i);
  assign finish  = running && (cnt_q == LAST);
  assign load_en = accept;
  assign step_en = running;
  assign hilo_en = finish && (op_q != OP_MULLO);
  assign mlo_en  = finish && (op_q == OP_MULLO);

  // datapath
  logic [2*W-1:0] acc_step;
  logic [W-1:0]   fix_hi, fix_lo;

  mdu_step #(.W(W)) u_step (
    .acc_i  (acc_q),
    .opnd_i (opnd_q),
    .div_i  (op_is_div(op_q)),
    .acc_o  (acc_step)
  );

  mdu_sign_fix #(.W(W)) u_fix (
    .raw_i   (acc_step),
    .div_i   (op_is_div(op_q)),
    .neg_a_i (nega_q),
    .neg_b_i (negb_q),
    .hi_o    (fix_hi),
    .lo_o    (fix_lo)
  );

  // next state
  always_comb begin
    state_d = state_q;
    if (accept) begin
      state_d = ST_RUN;
    end else if (finish) begin
      state_d = ST_IDLE;
    end
    cnt_d  = load_en ? '0 : (cnt_q + 1'b1);
    acc_d  = load_en ? {{W{1'b0}}, mag[0]} : acc_step;
    mvld_d = mlo_en;
  end

  // control registers with reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mvld_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      mlo_q   <= '0;
    end else begin
      state_q <= state_d;
      mvld_q  <= mvld_d;
      if (load_en || step_en) begin
        cnt_q <= cnt_d;
      end
      if (hilo_en) begin
        hi_q <= fix_hi;
        lo_q <= fix_lo;
      end
      if (mlo_en) begin
        mlo_q <= fix_lo;
      end
    end
  end

  // datapath registers without reset
  always_ff @(posedge clk) begin
    if (load_en || step_en) begin
      acc_q <= acc_d;
    end
    if (load_en) begin
      opnd_q <= mag[1];
      op_q   <= op_i;
      nega_q <= neg[0];
      negb_q <= neg[1];
    end
  end

  assign busy_o       = running;
  assign hi_o         = hi_q;
  assign lo_o         = lo_q;
  assign mul_lo_o     = mlo_q;
  assign mul_lo_vld_o = mvld_q;

endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic         busy_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o,
  input logic         mul_lo_vld_o
);

  localparam int BW = $clog2(W) + 2;

  logic [BW-1:0] bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else if (busy_o) begin
      bcnt_q <= bcnt_q + 1'b1;
    end else begin
      bcnt_q <= '0;
    end
  end

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(busy_o)) |-> (bcnt_q == BW'(W)));

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (op_i <= 3'd4)) |=> busy_o);

  p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (op_i > 3'd4)) |=> !busy_o);

  p_hilo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> ($stable(hi_o) && $stable(lo_o)));

  p_vld_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_lo_vld_o |-> $fell(busy_o));

  p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_lo_vld_o |=> !mul_lo_vld_o);

endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .start_i      (start_i),
  .op_i         (op_i),
  .busy_o       (busy_o),
  .hi_o         (hi_o),
  .lo_o         (lo_o),
  .mul_lo_vld_o (mul_lo_vld_o)
);

// File: tb/tb_mdu_hilo.sv
`timescale 1ns/1ps
module tb_mdu_hilo;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic [31:0] opa_i, opb_i;
  logic        busy_o;
  logic [31:0] hi_o, lo_o, mul_lo_o;
  logic        mul_lo_vld_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  mdu_hilo #(.W(32)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .op_i         (op_i),
    .opa_i        (opa_i),
    .opb_i        (opb_i),
    .busy_o       (busy_o),
    .hi_o         (hi_o),
    .lo_o         (lo_o),
    .mul_lo_o     (mul_lo_o),
    .mul_lo_vld_o (mul_lo_vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {HI,LO} (or low product in [31:0]) from the requirements
  function automatic logic [63:0] expect_hl(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'b0, a};
    ub = {32'b0, b};
    q = 0;
    r = 0;
    case (op)
      3'd0, 3'd4: return 64'(sa * sb);
      3'd1:       return ua * ub;
      3'd2: begin
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default:    return {a % b, a / b};
    endcase
  endfunction

  // launch one operation; intrude>0 raises a foreign start on that busy cycle
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input int intrude);
    logic [31:0] hi0, lo0;
    logic [63:0] exp;
    int cyc;
    bit held;
    string tg;
    hi0 = hi_o;
    lo0 = lo_o;
    held = 1;
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0; opa_i = ~a; opb_i = b ^ 32'h5a5a_0001;
    cyc = 0;
    while (busy_o && cyc < 100) begin
      cyc++;
      if (hi_o !== hi0 || lo_o !== lo0) held = 0;
      if (cyc == intrude) begin
        start_i = 1'b1; op_i = (op == 3'd1) ? 3'd2 : 3'd1;
        opa_i = 32'hdead_beef; opb_i = 32'd7;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    tg = (intrude > 0) ? "R8" : "R7";
    check(cyc == 32, {tg, " busy length"}, 64'(cyc), 64'd32);
    check(held, "R10 HI/LO held while busy", {hi_o, lo_o}, {hi0, lo0});
    exp = expect_hl(op, a, b);
    if (op == 3'd4) begin
      check(mul_lo_vld_o === 1'b1, "R6 valid pulse", 64'(mul_lo_vld_o), 64'd1);
      check(mul_lo_o === exp[31:0], "R6 low product", 64'(mul_lo_o), 64'(exp[31:0]));
      check({hi_o, lo_o} === {hi0, lo0}, "R6 HI/LO untouched", {hi_o, lo_o}, {hi0, lo0});
      @(negedge clk);
      check(mul_lo_vld_o === 1'b0, "R6 pulse one cycle", 64'(mul_lo_vld_o), 64'd0);
    end else if (op_is_div_tb(op) && b == 32'd0) begin
      check(busy_o === 1'b0, "R9 zero divisor completes", 64'(busy_o), 64'd0);
    end else begin
      case (op)
        3'd0: tg = "R2";
        3'd1: tg = "R3";
        3'd2: tg = "R4";
        default: tg = "R5";
      endcase
      if (intrude > 0) tg = {tg, "/R8"};
      check({hi_o, lo_o} === exp, {tg, " HI:LO"}, {hi_o, lo_o}, exp);
    end
    check(busy_o === 1'b0, {tg, " idle after"}, 64'(busy_o), 64'd0);
  endtask

  function automatic bit op_is_div_tb(input logic [2:0] op);
    return (op == 3'd2) || (op == 3'd3);
  endfunction

  task automatic bad_op(input logic [2:0] code);
    logic [31:0] hi0, lo0;
    hi0 = hi_o;
    lo0 = lo_o;
    @(negedge clk);
    start_i = 1'b1; op_i = code; opa_i = 32'd9; opb_i = 32'd4;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b0, "R8 unknown code ignored", 64'(busy_o), 64'd0);
    @(negedge clk);
    check(busy_o === 1'b0, "R8 unknown code stays idle", 64'(busy_o), 64'd0);
    check({hi_o, lo_o} === {hi0, lo0}, "R10 HI/LO hold idle", {hi_o, lo_o}, {hi0, lo0});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; start_i = 1'b0; op_i = 3'd0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0, "R1 busy in reset", 64'(busy_o), 64'd0);
    check({hi_o, lo_o} === 64'd0, "R1 HI/LO in reset", {hi_o, lo_o}, 64'd0);
    check(mul_lo_o === 32'd0 && mul_lo_vld_o === 1'b0, "R1 low-word port in reset",
          {mul_lo_o, 31'd0, mul_lo_vld_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    run_op(3'd1, 32'd5, 32'd3, 0);                    // R3: 5*3 -> HI 0, LO 15
    run_op(3'd0, 32'd5, 32'd3, 0);                    // R2
    run_op(3'd0, 32'hffff_ffff, 32'hffff_ffff, 0);    // R2: -1*-1
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 0);    // R2
    run_op(3'd1, 32'hffff_ffff, 32'hffff_ffff, 0);    // R3
    run_op(3'd0, 32'h8000_0000, 32'd7, 0);            // R2 mixed sign
    run_op(3'd2, 32'hffff_fff9, 32'd2, 0);            // R4: -7/2
    run_op(3'd2, 32'd7, 32'hffff_fffe, 0);            // R4: 7/-2
    run_op(3'd2, 32'h8000_0000, 32'hffff_ffff, 0);    // R4 most negative / -1
    run_op(3'd3, 32'hffff_ffff, 32'd10, 0);           // R5
    run_op(3'd3, 32'd3, 32'd10, 0);                   // R5 dividend below divisor
    run_op(3'd4, 32'hffff_fffd, 32'd11, 0);           // R6
    run_op(3'd3, 32'd123, 32'd0, 0);                  // R9
    run_op(3'd2, 32'hffff_ff00, 32'd0, 0);            // R9
    run_op(3'd3, 32'd100, 32'd7, 0);                  // R9 recovery
    run_op(3'd0, 32'd1234, 32'hffff_fff0, 32);        // R8 start on last busy cycle
    run_op(3'd4, 32'd77, 32'd3, 32);                  // R8 with low-word op
    run_op(3'd3, 32'd1000, 32'd33, 1);                // R8 start on first busy cycle
    bad_op(3'd5);
    bad_op(3'd6);
    bad_op(3'd7);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      logic [31:0] a, b;
      int intr;
      op = 3'($urandom % 5);
      a  = $urandom;
      b  = $urandom;
      if ($urandom % 3 == 0) b = b & 32'h0000_00ff;
      if ($urandom % 5 == 0) a = -a;
      intr = ($urandom % 4 == 0) ? int'(1 + $urandom % 32) : 0;
      run_op(op, a, b, intr);
      if ($urandom % 8 == 0) bad_op(3'(5 + $urandom % 3));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule